// File: doc/BRIEF.md
# Dual-Bank IN Endpoint Transmit Buffer

This block sits between a device CPU and the transmit engine of one USB IN endpoint. The CPU pushes bytes into the bank it currently owns through a byte write port and commits that bank with a one-cycle commit strobe. The host side reads the oldest committed bank one byte per request and then signals that the transfer finished, which frees the bank. With two banks in use the CPU can fill one bank while the host drains the other. The banks always alternate in a fixed order.

The block reports the number of busy banks and whether a write is currently accepted. It can discard the most recently committed bank when a transfer is aborted. In isochronous mode it hands the filled bank over on every start of frame and ignores the commit strobe. It tracks an 11-bit frame number and produces a substitute start-of-frame tick when a real one fails to arrive within a programmable window. Three sticky event flags drive one interrupt output through per-flag enables: bank free, frame tick and host underrun.

Top module: `inep_bank_ctrl`

## Requirements
- R1: Bytes reach the host in the order they were written. Committed banks are drained oldest first, and in two-bank mode the banks alternate strictly.
- R2: After a commit or a host completion, flag bit 0 (bank free) is set in that same step if the bank the CPU writes next is free. It is not set when that bank is still busy.
- R3: `wr_allowed` is high only while the CPU's bank is free, holds fewer than `PKT_BYTES` bytes and no kill is running. A write offered while it is low is not stored.
- R4: `busy_banks` counts committed banks that have not been freed, up to 2 in two-bank mode and up to 1 in one-bank mode. A commit while the CPU's bank is busy has no effect.
- R5: A host read of a busy bank returns the next byte, with `host_rd_valid`, one cycle after `host_rd_en`. A read beyond the committed length gives no valid byte. `host_done` frees the bank being read.
- R6: A one-cycle `kill_req` raises `kill_busy` for exactly one cycle. In that cycle the most recently committed busy bank is freed and becomes the CPU's bank again. When no bank is busy, nothing changes.
- R7: In isochronous mode the commit strobe has no effect. Each start-of-frame tick marks the CPU's bank busy if it holds data and hands it to the host side.
- R8: A real start of frame (`sof_in`) loads `frame_num` from `sof_fnum` at the next edge and sets flag bit 1 (frame).
- R9: Once a real start of frame has been seen and `sof_window` is non-zero, a substitute tick occurs `sof_window` cycles after the last tick, real or substitute, if no real one arrives. The substitute tick increments `frame_num` modulo 2048 and sets flag bit 1. A window of 0 disables substitute ticks.
- R10: A host read while no bank is busy sets flag bit 2 (underrun) and returns no valid byte.
- R11: Each flag stays set until a 1 is written to the same bit of `irq_clr`. `irq` is high exactly when some flag bit and the same `irq_en` bit are both 1.
- R12: After reset no bank is busy, `wr_allowed` is 1, all flags are 0, `frame_num` is 0, and `kill_busy` and `host_rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_bank | input | 1 | 1 selects two banks, 0 selects one |
| iso_mode | input | 1 | Banks switch on start of frame; commit ignored |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 8 | CPU write byte |
| cpu_commit | input | 1 | Hand the CPU's bank to the host side |
| kill_req | input | 1 | Discard the latest committed bank |
| host_rd_en | input | 1 | Host byte read request |
| host_done | input | 1 | Host finished the current bank |
| sof_in | input | 1 | Real start-of-frame pulse |
| sof_fnum | input | 11 | Frame number carried by the real start of frame |
| sof_window | input | 16 | Substitute-tick timeout in cycles, 0 disables |
| irq_en | input | 3 | Per-flag interrupt enables |
| irq_clr | input | 3 | Write-one-to-clear strobes for the flags |
| host_rd_data | output | 8 | Byte returned to the host |
| host_rd_valid | output | 1 | `host_rd_data` holds a byte |
| wr_allowed | output | 1 | CPU write is accepted |
| busy_banks | output | 2 | Number of busy banks |
| kill_busy | output | 1 | Kill in progress |
| flags | output | 3 | Sticky flags: bit 0 bank free, bit 1 frame, bit 2 underrun |
| frame_num | output | 11 | Current frame number |
| irq | output | 1 | Combined interrupt |

## Verification
If a bank pointer slips, it shows at the host port within one bank. Bytes come out of order or repeat, or a committed bank yields nothing, so the scoreboard catches it on the first read after the fault. If busy state is lost or invented, `busy_banks`, `wr_allowed` and the bank-free flag show it on the edge after the commit, completion or kill that caused it. A frame timer that is one cycle off moves the substitute tick, so `frame_num` and the frame flag are sampled on the cycle just before and just after the expected tick.

// File: rtl/inep_pkg.sv
package inep_pkg;
    localparam int FLAG_FREE  = 0;
    localparam int FLAG_FRAME = 1;
    localparam int FLAG_UNDER = 2;
    localparam int NFLAGS     = 3;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_COMMIT,
        EV_ISO,
        EV_KILL
    } bank_ev_e;

    typedef struct packed {
        logic under;
        logic frame;
        logic free;
    } flag_set_t;

    function automatic logic advance(input logic ptr, input logic two);
        return ptr ^ two;
    endfunction
endpackage

// File: rtl/inep_frame_timer.sv
module inep_frame_timer #(
    parameter int FNUM_W = 11,
    parameter int WIN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_in,
    input  logic [FNUM_W-1:0] sof_fnum,
    input  logic [WIN_W-1:0]  window,
    output logic              sof_tick,
    output logic [FNUM_W-1:0] frame_num
);
    logic             armed;
    logic [WIN_W-1:0] cnt;
    logic             pseudo;

    assign pseudo   = armed && (window != '0) && !sof_in && (cnt == window - WIN_W'(1));
    assign sof_tick = sof_in | pseudo;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            cnt       <= '0;
            frame_num <= '0;
        end else if (sof_in) begin
            armed     <= 1'b1;
            cnt       <= '0;
            frame_num <= sof_fnum;
        end else if (pseudo) begin
            cnt       <= '0;
            frame_num <= frame_num + FNUM_W'(1);
        end else if (armed) begin
            cnt <= cnt + WIN_W'(1);
        end
    end
endmodule

// File: rtl/inep_irq_flags.sv
module inep_irq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end

    assign irq = |(flags & en);
endmodule

// File: rtl/inep_bank_fsm.sv
module inep_bank_fsm
    import inep_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PKT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dual,
    input  logic              iso,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              kill_req,
    input  logic              rd_en,
    input  logic              done,
    input  logic              sof_tick,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              wr_allowed,
    output logic [1:0]        busy_banks,
    output logic              kill_busy,
    output logic              free_set,
    output logic              under_set
);
    localparam int CNT_W = $clog2(PKT_BYTES + 1);
    localparam int IDX_W = $clog2(PKT_BYTES);

    logic [DATA_W-1:0] mem [0:1][0:PKT_BYTES-1];
    logic [CNT_W-1:0]  len [0:1];
    logic [1:0]        full, nxt_full;
    logic              wr_ptr, rd_ptr, nxt_wp, nxt_rp;
    logic [CNT_W-1:0]  wcnt, ridx;
    logic              last_bank, done_ok, rd_ok, do_write;
    bank_ev_e          ev;

    assign last_bank  = dual ? ~wr_ptr : wr_ptr;
    assign wr_allowed = !full[wr_ptr] && (wcnt < CNT_W'(PKT_BYTES)) && !kill_busy;
    assign do_write   = wr_en && wr_allowed && (ev == EV_NONE);
    assign busy_banks = {1'b0, full[0]} + {1'b0, full[1]};

    always_comb begin
        ev = EV_NONE;
        if (kill_busy)                       ev = EV_KILL;
        else if (iso && sof_tick)            ev = EV_ISO;
        else if (!iso && commit && !full[wr_ptr]) ev = EV_COMMIT;
    end

    assign done_ok   = done && full[rd_ptr] && (ev == EV_NONE || ev == EV_COMMIT);
    assign rd_ok     = rd_en && full[rd_ptr] && !kill_busy;
    assign under_set = rd_en && !full[rd_ptr] && !kill_busy;

    always_comb begin
        nxt_full = full;
        nxt_wp   = wr_ptr;
        nxt_rp   = rd_ptr;
        case (ev)
            EV_KILL: begin
                if (full[last_bank]) begin
                    nxt_full[last_bank] = 1'b0;
                    nxt_wp              = last_bank;
                end
            end
            EV_ISO: begin
                nxt_full[wr_ptr] = full[wr_ptr] | (wcnt != '0);
                if (dual) begin
                    nxt_full[~wr_ptr] = 1'b0;
                    nxt_wp            = ~wr_ptr;
                    nxt_rp            = wr_ptr;
                end
            end
            EV_COMMIT: begin
                nxt_full[wr_ptr] = 1'b1;
                nxt_wp           = advance(wr_ptr, dual);
            end
            default: ;
        endcase
        if (done_ok) begin
            nxt_full[rd_ptr] = 1'b0;
            nxt_rp           = advance(rd_ptr, dual);
        end
    end

    assign free_set = (ev == EV_COMMIT || done_ok) && !nxt_full[nxt_wp];

    always_ff @(posedge clk) begin
        if (do_write) mem[wr_ptr][wcnt[IDX_W-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full      <= '0;
            wr_ptr    <= 1'b0;
            rd_ptr    <= 1'b0;
            wcnt      <= '0;
            ridx      <= '0;
            kill_busy <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            len[0]    <= '0;
            len[1]    <= '0;
        end else begin
            full      <= nxt_full;
            wr_ptr    <= nxt_wp;
            rd_ptr    <= nxt_rp;
            kill_busy <= kill_busy ? 1'b0 : kill_req;
            rd_valid  <= 1'b0;
            if (ev == EV_COMMIT || ev == EV_ISO) begin
                len[wr_ptr] <= wcnt;
                wcnt        <= '0;
            end else if (ev == EV_KILL) begin
                wcnt <= '0;
            end else if (do_write) begin
                wcnt <= wcnt + CNT_W'(1);
            end
            if (rd_ok && (ridx < len[rd_ptr])) begin
                rd_data  <= mem[rd_ptr][ridx[IDX_W-1:0]];
                rd_valid <= 1'b1;
                ridx     <= ridx + CNT_W'(1);
            end
            if ((nxt_rp != rd_ptr) || (full[rd_ptr] && !nxt_full[rd_ptr])) ridx <= '0;
        end
    end
endmodule

// File: rtl/inep_bank_ctrl.sv
module inep_bank_ctrl
    import inep_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PKT_BYTES = 8,
    parameter int FNUM_W    = 11,
    parameter int WIN_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dual_bank,
    input  logic              iso_mode,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_commit,
    input  logic              kill_req,
    input  logic              host_rd_en,
    input  logic              host_done,
    input  logic              sof_in,
    input  logic [FNUM_W-1:0] sof_fnum,
    input  logic [WIN_W-1:0]  sof_window,
    input  logic [NFLAGS-1:0] irq_en,
    input  logic [NFLAGS-1:0] irq_clr,
    output logic [DATA_W-1:0] host_rd_data,
    output logic              host_rd_valid,
    output logic              wr_allowed,
    output logic [1:0]        busy_banks,
    output logic              kill_busy,
    output logic [NFLAGS-1:0] flags,
    output logic [FNUM_W-1:0] frame_num,
    output logic              irq
);
    logic      sof_tick;
    flag_set_t set_ev;

    inep_frame_timer #(.FNUM_W(FNUM_W), .WIN_W(WIN_W)) u_timer (
        .clk(clk), .rst(rst), .sof_in(sof_in), .sof_fnum(sof_fnum),
        .window(sof_window), .sof_tick(sof_tick), .frame_num(frame_num)
    );

    inep_bank_fsm #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_banks (
        .clk(clk), .rst(rst), .dual(dual_bank), .iso(iso_mode),
        .wr_en(cpu_wr_en), .wr_data(cpu_wr_data), .commit(cpu_commit),
        .kill_req(kill_req), .rd_en(host_rd_en), .done(host_done),
        .sof_tick(sof_tick), .rd_data(host_rd_data), .rd_valid(host_rd_valid),
        .wr_allowed(wr_allowed), .busy_banks(busy_banks), .kill_busy(kill_busy),
        .free_set(set_ev.free), .under_set(set_ev.under)
    );

    assign set_ev.frame = sof_tick;

    inep_irq_flags #(.N(NFLAGS)) u_flags (
        .clk(clk), .rst(rst), .set(set_ev), .clr(irq_clr), .en(irq_en),
        .flags(flags), .irq(irq)
    );
endmodule

// File: rtl/inep_bank_ctrl_chk.sv
module inep_bank_ctrl_chk #(
    parameter int FNUM_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              dual_bank,
    input logic              kill_req,
    input logic              kill_busy,
    input logic [1:0]        busy_banks,
    input logic              wr_allowed,
    input logic              host_rd_en,
    input logic [2:0]        flags,
    input logic [2:0]        irq_clr,
    input logic              sof_in,
    input logic [FNUM_W-1:0] sof_fnum,
    input logic [FNUM_W-1:0] frame_num
);
    // R4: busy count bounded by bank mode
    a_r4_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy_banks <= (dual_bank ? 2'd2 : 2'd1));

    // R3: no write accepted while both banks are busy
    a_r3_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (busy_banks == 2'd2) |-> !wr_allowed);

    // R6: kill lasts one cycle
    a_r6_kill_one_cycle: assert property (@(posedge clk) disable iff (rst)
        kill_busy |=> !kill_busy);

    // R6: kill starts after a request
    a_r6_kill_starts: assert property (@(posedge clk) disable iff (rst)
        (kill_req && !kill_busy) |=> kill_busy);

    // R6: kill frees exactly one busy bank
    a_r6_kill_drops_one: assert property (@(posedge clk) disable iff (rst)
        (kill_busy && busy_banks != 2'd0) |=> (busy_banks == $past(busy_banks) - 2'd1));

    // R10: read with no busy bank flags underrun
    a_r10_underrun: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && busy_banks == 2'd0 && !kill_busy) |=> flags[2]);

    // R8: real start of frame loads the frame number
    a_r8_fnum_load: assert property (@(posedge clk) disable iff (rst)
        sof_in |=> (frame_num == $past(sof_fnum)));

    // R9: without a real start of frame the number holds or steps by one
    a_r9_fnum_step: assert property (@(posedge clk) disable iff (rst)
        !sof_in |=> (frame_num == $past(frame_num) || frame_num == $past(frame_num) + FNUM_W'(1)));

    // R11: flags are sticky until cleared
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags != 3'b000) |=> ((flags & $past(flags & ~irq_clr)) == $past(flags & ~irq_clr)));
endmodule

bind inep_bank_ctrl inep_bank_ctrl_chk #(.FNUM_W(FNUM_W)) u_chk (.*);

// File: tb/tb_inep_bank_ctrl.sv
module tb_inep_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dual_bank = 1'b1, iso_mode = 1'b0;
    logic        cpu_wr_en = 1'b0, cpu_commit = 1'b0, kill_req = 1'b0;
    logic [7:0]  cpu_wr_data = '0;
    logic        host_rd_en = 1'b0, host_done = 1'b0, sof_in = 1'b0;
    logic [10:0] sof_fnum = '0;
    logic [15:0] sof_window = '0;
    logic [2:0]  irq_en = 3'b111, irq_clr = 3'b000;
    logic [7:0]  host_rd_data;
    logic        host_rd_valid, wr_allowed, kill_busy, irq;
    logic [1:0]  busy_banks;
    logic [2:0]  flags;
    logic [10:0] frame_num;

    int checks = 0, fails = 0;
    logic [7:0] exp_q[$];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    inep_bank_ctrl dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic write_bytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            cpu_wr_en = 1'b1; cpu_wr_data = base + 8'(i); step();
        end
        cpu_wr_en = 1'b0;
    endtask

    task automatic commit();
        cpu_commit = 1'b1; step(); cpu_commit = 1'b0;
    endtask

    task automatic expect_bytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) exp_q.push_back(base + 8'(i));
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            host_rd_en = 1'b1; step();
        end
        host_rd_en = 1'b0;
        host_done = 1'b1; step(); host_done = 1'b0;
    endtask

    task automatic clear_flags();
        irq_clr = 3'b111; step(); irq_clr = 3'b000;
    endtask

    task automatic pulse_sof(input logic [10:0] fn);
        sof_in = 1'b1; sof_fnum = fn; step(); sof_in = 1'b0;
    endtask

    task automatic do_kill();
        kill_req = 1'b1; step(); kill_req = 1'b0;
        chk(kill_busy == 1'b1, "R6 kill busy raised", kill_busy, 1);
        step();
        chk(kill_busy == 1'b0, "R6 kill busy drops", kill_busy, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && host_rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", host_rd_data, -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(host_rd_data == e, "R1 byte order", host_rd_data, e);
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R12 reset state
        chk(busy_banks == 0, "R12 busy", busy_banks, 0);
        chk(wr_allowed == 1, "R12 wr_allowed", wr_allowed, 1);
        chk(flags == 0, "R12 flags", flags, 0);
        chk(frame_num == 0, "R12 frame", frame_num, 0);
        chk(kill_busy == 0 && host_rd_valid == 0, "R12 kill/valid", kill_busy, 0);

        // R3 fill a bank, extra write ignored
        write_bytes(8, 8'h10);
        chk(wr_allowed == 0, "R3 full bank blocks", wr_allowed, 0);
        cpu_wr_en = 1'b1; cpu_wr_data = 8'hEE; step(); cpu_wr_en = 1'b0;
        commit();
        chk(busy_banks == 1, "R4 one busy", busy_banks, 1);
        chk(flags[0] == 1, "R2 free set on commit", flags[0], 1);
        chk(wr_allowed == 1, "R3 second bank open", wr_allowed, 1);
        chk(irq == 1, "R11 irq enabled", irq, 1);
        clear_flags();
        chk(flags == 0 && irq == 0, "R11 clear", flags, 0);

        write_bytes(5, 8'h40);
        commit();
        chk(busy_banks == 2, "R4 two busy", busy_banks, 2);
        chk(flags[0] == 0, "R2 no free when next busy", flags[0], 0);
        chk(wr_allowed == 0, "R3 both busy", wr_allowed, 0);
        commit();
        chk(busy_banks == 2, "R4 commit on busy ignored", busy_banks, 2);

        expect_bytes(8, 8'h10);
        drain(8);
        chk(busy_banks == 1, "R5 done frees", busy_banks, 1);
        chk(flags[0] == 1, "R2 free set on done", flags[0], 1);
        expect_bytes(5, 8'h40);
        drain(6);
        chk(busy_banks == 0, "R5 second done", busy_banks, 0);
        chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);

        // R10 and R11 gating
        clear_flags();
        host_rd_en = 1'b1; step(); host_rd_en = 1'b0;
        chk(flags == 3'b100, "R10 underrun", flags, 4);
        chk(host_rd_valid == 0, "R10 no valid", host_rd_valid, 0);
        irq_en = 3'b011; #1;
        chk(irq == 0, "R11 masked", irq, 0);
        irq_en = 3'b100; #1;
        chk(irq == 1, "R11 unmasked", irq, 1);
        irq_en = 3'b111;
        clear_flags();

        // R6 kill with two busy
        write_bytes(3, 8'h60); commit();
        write_bytes(4, 8'h70); commit();
        do_kill();
        chk(busy_banks == 1, "R6 one bank dropped", busy_banks, 1);
        write_bytes(2, 8'h80); commit();
        chk(busy_banks == 2, "R6 killed bank reused", busy_banks, 2);
        expect_bytes(3, 8'h60);
        drain(3);
        expect_bytes(2, 8'h80);
        drain(2);
        chk(busy_banks == 0, "R1 drained after kill", busy_banks, 0);
        do_kill();
        chk(busy_banks == 0, "R6 kill idle", busy_banks, 0);
        write_bytes(2, 8'h90); commit();
        do_kill();
        chk(busy_banks == 0, "R6 kill single busy", busy_banks, 0);
        write_bytes(1, 8'hA0); commit();
        expect_bytes(1, 8'hA0);
        drain(1);
        chk(exp_q.size() == 0, "R6 killed data absent", exp_q.size(), 0);

        // one-bank mode
        dual_bank = 1'b0;
        clear_flags();
        write_bytes(8, 8'hB0); commit();
        chk(busy_banks == 1, "R4 single busy", busy_banks, 1);
        chk(wr_allowed == 0, "R3 single blocked", wr_allowed, 0);
        chk(flags[0] == 0, "R2 single no free", flags[0], 0);
        expect_bytes(8, 8'hB0);
        drain(8);
        chk(flags[0] == 1 && busy_banks == 0, "R2 single free on done", flags[0], 1);
        dual_bank = 1'b1;

        // R7 isochronous
        iso_mode = 1'b1;
        clear_flags();
        write_bytes(3, 8'hC0); commit();
        chk(busy_banks == 0, "R7 commit ignored", busy_banks, 0);
        pulse_sof(11'd5);
        chk(busy_banks == 1, "R7 sof hands bank", busy_banks, 1);
        chk(frame_num == 5, "R8 frame load", frame_num, 5);
        chk(flags[1] == 1, "R8 frame flag", flags[1], 1);
        expect_bytes(3, 8'hC0);
        drain(3);
        chk(busy_banks == 0, "R7 iso drained", busy_banks, 0);
        iso_mode = 1'b0;

        // R9 substitute tick
        sof_window = 16'd20;
        pulse_sof(11'd100);
        clear_flags();
        repeat (18) step();
        chk(frame_num == 100 && flags[1] == 0, "R9 before tick", frame_num, 100);
        step();
        chk(frame_num == 101, "R9 tick increments", frame_num, 101);
        chk(flags[1] == 1, "R9 tick flag", flags[1], 1);
        pulse_sof(11'd2047);
        repeat (20) step();
        chk(frame_num == 0, "R9 wrap", frame_num, 0);
        sof_window = 16'd0;
        repeat (40) step();
        chk(frame_num == 0, "R9 disabled", frame_num, 0);

        step();
        chk(exp_q.size() == 0, "R1 queue empty", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule